// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic stage of a 16-bit accumulator machine. Each cycle it takes the accumulator value, the value of one selected operand register and an operation code, and returns, in the same cycle, the result, a destination select and the decision for a flag-based conditional jump. The destination select says whether the result goes to the accumulator, to the operand register, or nowhere. The register file acts on that select; it is not part of this block.

Three flags are held in registers: zero, carry/borrow and negative. They load at the clock edge that ends a valid arithmetic, logic or shift operation. Between operations they keep their value, so a later jump instruction can test them. The jump decision is formed only from these stored flags. Add-with-carry takes in the stored carry, so wider sums can be built one 16-bit word at a time.

The interface is plain control, with no handshake. Whenever `op_valid` is high, the operation is accepted in that cycle. The block never stalls, so it has no ready signal and no back-pressure.

Top module: `acc_alu`

## Requirements
- R1: Operation codes are 0 add, 1 subtract, 3 and, 4 or, 5 xor and 7 add-with-carry. Each one computes accumulator (op) operand, truncated to 16 bits, and drives dest = 1 (accumulator). Subtract computes A minus operand.
- R2: Operation code 2 (reverse subtract) computes operand minus A and drives dest = 2 (operand register).
- R3: Operation code 6 (compare) drives dest = 0 (no write). It loads the flags from the trial difference A minus operand.
- R4: Add-with-carry adds the stored carry flag to A plus operand. The carry out of that sum becomes the new carry.
- R5: After every valid operation with code 0 to 9, the zero flag is 1 exactly when the 16-bit result is 0, and the negative flag equals bit 15 of the result.
- R6: The carry flag is loaded as follows. Add and add-with-carry load the carry out of bit 15. Subtract, reverse subtract and compare load 1 when the subtraction borrowed, that is, when the subtrahend is larger unsigned. And, or and xor load 0.
- R7: Operation code 8 shifts A left by one place and code 9 shifts A right by one place. The bit that is shifted in is 0. The bit that is shifted out loads the carry flag, and dest = 1.
- R8: The jump select codes are 0 equal (Z=1), 1 not equal (Z=0), 2 above (C=0 and Z=0) and 3 below (C=1). `jump_taken` is decided from the stored flags only, in the same cycle the select is applied.
- R9: The flags keep their value, and dest = 0, whenever `op_valid` is low or the operation code is 10 to 15.
- R10: Reset (rst_n low) clears all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 4 | Operation code |
| acc_in | input | 16 | Accumulator value |
| opr_in | input | 16 | Selected operand register value |
| jump_sel | input | 2 | Jump condition select |
| result | output | 16 | Combinational result |
| dest | output | 2 | 0 none, 1 accumulator, 2 operand register |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry/borrow flag |
| flag_n | output | 1 | Stored negative flag |
| jump_taken | output | 1 | Decision for the selected condition |

## Verification
`result` and `dest` are combinational, so they are due in the same cycle that the operation is applied. The flags, and any jump decision that depends on them, change only one edge later. Each stimulus is driven on a falling edge. The monitor compares `result`, `dest` and `jump_taken` shortly before the next rising edge, and it compares the flags against the model state left by all earlier operations. The flags written by an operation are therefore always checked in the following cycle, which also covers the cases where the flags must hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SUBR = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_CMP  = 4'd6,
    OP_ADC  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_OPR  = 2'd2
  } dest_e;

  typedef enum logic [1:0] {
    JC_EQ = 2'd0,
    JC_NE = 2'd1,
    JC_AB = 2'd2,
    JC_BL = 2'd3
  } jcond_e;
endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         valid,
  input  logic [3:0]   code,
  input  logic [W-1:0] a,
  input  logic [W-1:0] r,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic [1:0]   dst,
  output logic         nz,
  output logic         nc,
  output logic         nn,
  output logic         upd
);
  localparam int MSB = W - 1;

  logic [W:0] sum_ar;
  logic [W:0] dif_ar;
  logic [W:0] dif_ra;
  logic [W:0] sum_adc;

  assign sum_ar  = {1'b0, a} + {1'b0, r};
  assign dif_ar  = {1'b0, a} - {1'b0, r};
  assign dif_ra  = {1'b0, r} - {1'b0, a};
  assign sum_adc = sum_ar + {{W{1'b0}}, cin};

  always_comb begin
    res = '0;
    dst = DST_NONE;
    nc  = 1'b0;
    upd = valid;
    case (code)
      OP_ADD:  begin res = sum_ar[MSB:0];  nc = sum_ar[W];  dst = DST_ACC; end
      OP_SUB:  begin res = dif_ar[MSB:0];  nc = dif_ar[W];  dst = DST_ACC; end
      OP_SUBR: begin res = dif_ra[MSB:0];  nc = dif_ra[W];  dst = DST_OPR; end
      OP_AND:  begin res = a & r;          dst = DST_ACC; end
      OP_OR:   begin res = a | r;          dst = DST_ACC; end
      OP_XOR:  begin res = a ^ r;          dst = DST_ACC; end
      OP_CMP:  begin res = dif_ar[MSB:0];  nc = dif_ar[W];  end
      OP_ADC:  begin res = sum_adc[MSB:0]; nc = sum_adc[W]; dst = DST_ACC; end
      OP_SHL:  begin res = {a[MSB-1:0], 1'b0}; nc = a[MSB]; dst = DST_ACC; end
      OP_SHR:  begin res = {1'b0, a[MSB:1]};   nc = a[0];   dst = DST_ACC; end
      default: begin upd = 1'b0; end
    endcase
    if (!valid) dst = DST_NONE;
    nz = (res == '0);
    nn = res[MSB];
  end

  always_comb begin
    if (valid && (code == OP_SHR)) begin
      a_r7_shr_fill: assert (res[MSB] == 1'b0);
    end
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic nz,
  input  logic nc,
  input  logic nn,
  output logic z,
  output logic c,
  output logic n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z <= 1'b0;
      c <= 1'b0;
      n <= 1'b0;
    end else if (upd) begin
      z <= nz;
      c <= nc;
      n <= nn;
    end
  end

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable({z, c, n}));

  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |=> ({z, c, n} == 3'b000));
endmodule

// File: rtl/acc_alu_jump.sv
module acc_alu_jump
  import acc_alu_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       z,
  input  logic       c,
  output logic       taken
);
  always_comb begin
    case (sel)
      JC_EQ:   taken = z;
      JC_NE:   taken = !z;
      JC_AB:   taken = !c && !z;
      default: taken = c;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opr_in,
  input  logic [1:0]   jump_sel,
  output logic [W-1:0] result,
  output logic [1:0]   dest,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_n,
  output logic         jump_taken
);
  logic nz, nc, nn, upd;

  acc_alu_core #(.W(W)) u_core (
    .valid(op_valid), .code(op_code), .a(acc_in), .r(opr_in), .cin(flag_c),
    .res(result), .dst(dest), .nz(nz), .nc(nc), .nn(nn), .upd(upd)
  );

  acc_alu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .upd(upd), .nz(nz), .nc(nc), .nn(nn),
    .z(flag_z), .c(flag_c), .n(flag_n)
  );

  acc_alu_jump u_jump (
    .sel(jump_sel), .z(flag_z), .c(flag_c), .taken(jump_taken)
  );

  a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |-> dest == DST_NONE);

  a_r2_subr_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SUBR) |-> dest == DST_OPR);

  a_r8_above_not_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_sel == JC_AB && jump_taken) |-> !flag_z);

  a_r9_idle_no_dest: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> dest == DST_NONE);

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 4'd9) |=> flag_z == ($past(result) == '0));
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [15:0] acc_in = 16'd0;
  logic [15:0] opr_in = 16'd0;
  logic [1:0]  jump_sel = 2'd0;
  logic [15:0] result;
  logic [1:0]  dest;
  logic        flag_z, flag_c, flag_n, jump_taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [15:0] res;
    logic [1:0]  dst;
    logic [2:0]  flg;
    logic        tk;
  } item_t;
  item_t q[$];

  logic mz = 0, mc = 0, mn = 0;

  always #4 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opr_in(opr_in), .jump_sel(jump_sel), .result(result),
    .dest(dest), .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n),
    .jump_taken(jump_taken)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic v, logic [3:0] op, logic [15:0] a,
                       logic [15:0] r, logic [1:0] js);
    item_t it;
    logic [16:0] t;
    logic [15:0] res;
    logic [1:0] dst;
    logic nc;
    logic known;
    @(negedge clk);
    op_valid = v; op_code = op; acc_in = a; opr_in = r; jump_sel = js;
    known = 1; res = 0; dst = 0; nc = 0;
    case (op)
      0: begin t = {1'b0,a} + {1'b0,r}; res = t[15:0]; nc = t[16]; dst = 1; end
      1: begin res = a - r; nc = (r > a); dst = 1; end
      2: begin res = r - a; nc = (a > r); dst = 2; end
      3: begin res = a & r; dst = 1; end
      4: begin res = a | r; dst = 1; end
      5: begin res = a ^ r; dst = 1; end
      6: begin res = a - r; nc = (r > a); end
      7: begin t = {1'b0,a} + {1'b0,r} + {16'd0,mc}; res = t[15:0]; nc = t[16]; dst = 1; end
      8: begin res = a << 1; nc = a[15]; dst = 1; end
      9: begin res = a >> 1; nc = a[0]; dst = 1; end
      default: known = 0;
    endcase
    if (!v) dst = 0;
    it.tag = tag;
    it.res = res;
    it.dst = dst;
    it.flg = {mz, mc, mn};
    case (js)
      0: it.tk = mz;
      1: it.tk = !mz;
      2: it.tk = !mc && !mz;
      default: it.tk = mc;
    endcase
    q.push_back(it);
    if (v && known) begin
      mz = (res == 16'd0); mc = nc; mn = res[15];
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.dst != 0) chk({it.tag, " result"}, {16'd0, result}, {16'd0, it.res});
        chk({it.tag, " dest"}, {30'd0, dest}, {30'd0, it.dst});
        chk({it.tag, " flags"}, {29'd0, flag_z, flag_c, flag_n}, {29'd0, it.flg});
        chk({it.tag, " jump"}, {31'd0, jump_taken}, {31'd0, it.tk});
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset flags", {29'd0, flag_z, flag_c, flag_n}, 32'd0);
    rst_n = 1'b1;
    // R1 / R5 / R6 add
    drive("R1 add",           1, 0, 16'h1234, 16'h0101, 0);
    drive("R6 add carry",     1, 0, 16'hFFFF, 16'h0001, 1);
    drive("R5 sub neg",       1, 1, 16'h0001, 16'h0002, 3);
    drive("R2 subr",          1, 2, 16'h0003, 16'h0010, 3);
    drive("R6 subr borrow",   1, 2, 16'h0010, 16'h0003, 2);
    drive("R1 and",           1, 3, 16'hF0F0, 16'hFF00, 3);
    drive("R1 or",            1, 4, 16'h8000, 16'h0001, 0);
    drive("R1 xor zero",      1, 5, 16'hA5A5, 16'hA5A5, 2);
    // R3 compare and R8 jumps
    drive("R3 cmp above",     1, 6, 16'h0200, 16'h0100, 0);
    drive("R8 above",         0, 0, 16'h0000, 16'h0000, 2);
    drive("R8 ne",            0, 0, 16'h0000, 16'h0000, 1);
    drive("R3 cmp below",     1, 6, 16'h0100, 16'h0200, 3);
    drive("R8 below",         0, 0, 16'h0000, 16'h0000, 3);
    drive("R8 above no",      0, 0, 16'h0000, 16'h0000, 2);
    drive("R3 cmp equal",     1, 6, 16'h7777, 16'h7777, 0);
    drive("R8 eq",            0, 0, 16'h0000, 16'h0000, 0);
    drive("R8 above eq",      0, 0, 16'h0000, 16'h0000, 2);
    // R4 carry chain: 0x0001_FFFF + 0x0000_0001
    drive("R4 low add",       1, 0, 16'hFFFF, 16'h0001, 3);
    drive("R4 adc high",      1, 7, 16'h0001, 16'h0000, 3);
    drive("R4 adc no cin",    1, 7, 16'hFFFF, 16'h0000, 3);
    drive("R4 adc wrap",      1, 7, 16'hFFFF, 16'h0001, 0);
    drive("R4 adc with cin",  1, 7, 16'h0000, 16'h0000, 3);
    // R7 shifts
    drive("R7 shl out",       1, 8, 16'h8001, 16'h0000, 3);
    drive("R7 shl",           1, 8, 16'h4000, 16'h0000, 3);
    drive("R7 shr out",       1, 9, 16'h8001, 16'h0000, 3);
    drive("R7 shr zero",      1, 9, 16'h0001, 16'h0000, 0);
    // R9 hold on idle and unused codes
    drive("R9 idle add",      0, 0, 16'h0001, 16'h0001, 0);
    drive("R9 unused code",   1, 4'd12, 16'h0001, 16'h0001, 1);
    drive("R9 unused code15", 1, 4'd15, 16'h8000, 16'h0000, 3);
    drive("R9 after hold",    0, 0, 16'h0000, 16'h0000, 0);
    drive("R1 sub",           1, 1, 16'h0500, 16'h0200, 3);
    drive("R6 sub flags",     0, 0, 16'h0000, 16'h0000, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule